// File: doc/BRIEF.md
# Strobe-Qualified Bus Write Trigger

This block watches the bus of a 68k-style host processor from the outside and raises a sticky flag when the processor writes to one programmed address. All bus lines are first retimed by a two-stage register chain on the host processor clock. The compare is made only on those clock edges, and only while both the address strobe and the data strobe are low. Bit skew while the address changes between edges cannot produce a false hit, even when the skew briefly forms the target address.

When the flag sets, the block freezes the address and data of the matching cycle. A slower controller reads that frozen 64-bit word one byte at a time through a 3-bit byte index, and the word does not change between those reads. A synchronous clear drops the flag and the frozen word. The target address, a per-bit compare mask, and an optional expected data value are static configuration inputs.

A small state machine tracks each bus cycle through three states. BS_IDLE means the address strobe is high. BS_ADDR means the address strobe is low and the data strobe has not yet fallen. BS_SPENT means the cycle's one evaluation has been used. The transitions are:
- BS_IDLE to BS_ADDR when the address strobe falls and the data strobe is still high.
- BS_IDLE to BS_SPENT when both strobes are low in the same sample. This is an evaluation.
- BS_ADDR to BS_SPENT when the data strobe falls while the address strobe is still low. This is an evaluation.
- BS_ADDR to BS_IDLE when the address strobe rises first.
- BS_SPENT to BS_IDLE when the address strobe rises.

Top module: `bus_write_trigger`

## Requirements
- R1: After reset, `trig` is 0 and every byte read through `rd_byte` is 0.
- R2: Bus inputs count only at rising edges of `clk`. An address that appears and disappears entirely between two edges, even one equal to the target, never sets `trig`.
- R3: A cycle is evaluated only on a sample in which `as_n` and `ds_n` are both 0. A cycle in which `as_n` is low but `ds_n` stays high never sets `trig`. If `ds_n` falls some cycles after `as_n`, that later sample is evaluated.
- R4: Read cycles (`rw` = 1) never set `trig`. Only write cycles (`rw` = 0) can match.
- R5: Address bit i takes part in the compare only where `cfg_addr_mask[i]` = 1. Bits with mask 0 are ignored.
- R6: With `cfg_data_en` = 1, a match also requires `bus_data` to equal `cfg_data` in all 32 bits. With `cfg_data_en` = 0, the data bus is ignored.
- R7: Once set, `trig` stays 1 and the frozen address and data stay unchanged through later bus activity until `clr` is asserted.
- R8: A bus cycle is evaluated only on its first qualified sample. While `as_n` stays low no further match can occur. A new match needs `as_n` to go high and then low again.
- R9: `clr` = 1 at a rising edge clears `trig` and the frozen word to 0 at that edge.
- R10: If `clr` and a new match fall on the same edge, the match wins: `trig` is 1 and the new address and data are frozen.
- R11: `rd_sel` values 0 to 3 return address bytes, least significant first. Values 4 to 7 return data bytes, least significant first.
- R12: A qualified matching write present at rising edge k sets `trig` after edge k+2, and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host processor clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 32 | Observed address bus |
| bus_data | input | 32 | Observed data bus |
| as_n | input | 1 | Address strobe, active low |
| ds_n | input | 1 | Data strobe, active low |
| rw | input | 1 | 1 = read cycle, 0 = write cycle |
| cfg_addr | input | 32 | Target address |
| cfg_addr_mask | input | 32 | 1 = compare this address bit |
| cfg_data_en | input | 1 | 1 = also require a data match |
| cfg_data | input | 32 | Expected write data |
| clr | input | 1 | Synchronous clear of flag and frozen word |
| rd_sel | input | 3 | Byte index into the frozen word |
| rd_byte | output | 8 | Selected byte of the frozen word |
| trig | output | 1 | Sticky trigger flag |

## Verification
Writes to the target are mixed with the following near misses:
- writes to other addresses;
- reads from the target;
- cycles where only the address strobe asserts;
- target-valued address glitches placed between clock edges;
- differences in masked bits compared with differences in compared bits;
- wrong data while the data check is enabled.

Each of these shows whether one qualifier gates the match. Strobes held low for many cycles, with a clear in the middle, show whether the state machine gives one evaluation per cycle and not one per sample. A clear that lands on the same edge as a new match shows the priority between the two. Sampling `trig` one edge at a time pins down the three-edge latency. All eight byte indexes are read back after each step, which shows how the frozen word is ordered and whether it was held or overwritten.

// File: rtl/bwt_pkg.sv
`timescale 1ns/1ps
package bwt_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [1:0] {
        BS_IDLE  = 2'd0,
        BS_ADDR  = 2'd1,
        BS_SPENT = 2'd2
    } bus_state_t;

endpackage

// File: rtl/bwt_sync.sv
`timescale 1ns/1ps
module bwt_sync #(
    parameter int          WIDTH   = 1,
    parameter logic [0:0]  RST_BIT = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);

    logic [WIDTH-1:0] stage_q;
    logic [WIDTH-1:0] out_q;

    // one retiming chain per bit, each resetting to the idle level
    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                stage_q[b] <= RST_BIT[0];
                out_q[b]   <= RST_BIT[0];
            end else begin
                stage_q[b] <= din[b];
                out_q[b]   <= stage_q[b];
            end
        end
    end

    assign dout = out_q;

endmodule

// File: rtl/bwt_cycle_fsm.sv
`timescale 1ns/1ps
module bwt_cycle_fsm
    import bwt_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic as_s,
    input  logic ds_s,
    output logic eval
);

    bus_state_t state_q;
    bus_state_t state_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= BS_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state and evaluate strobe
    always_comb begin
        state_d = state_q;
        eval    = 1'b0;
        unique case (state_q)
            BS_IDLE: begin
                if (!as_s) begin
                    if (!ds_s) begin
                        eval    = 1'b1;
                        state_d = BS_SPENT;
                    end else begin
                        state_d = BS_ADDR;
                    end
                end
            end
            BS_ADDR: begin
                if (as_s) begin
                    state_d = BS_IDLE;
                end else if (!ds_s) begin
                    eval    = 1'b1;
                    state_d = BS_SPENT;
                end
            end
            BS_SPENT: begin
                if (as_s) begin
                    state_d = BS_IDLE;
                end
            end
            default: begin
                state_d = BS_IDLE;
            end
        endcase
    end

    // R8
    one_eval_per_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eval |=> !eval);

    // R8
    spent_needs_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == BS_SPENT && !as_s) |=> (state_q == BS_SPENT));

    // R3
    eval_needs_strobes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eval |-> (!as_s && !ds_s));

endmodule

// File: rtl/bwt_match.sv
`timescale 1ns/1ps
module bwt_match #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input  logic              eval,
    input  logic              rw_s,
    input  logic [ADDR_W-1:0] addr_s,
    input  logic [DATA_W-1:0] data_s,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [ADDR_W-1:0] cfg_addr_mask,
    input  logic              cfg_data_en,
    input  logic [DATA_W-1:0] cfg_data,
    output logic              hit
);

    logic [ADDR_W-1:0] addr_diff;
    logic              addr_ok;
    logic              data_ok;

    // per-bit masked difference
    for (genvar i = 0; i < ADDR_W; i++) begin : g_abit
        assign addr_diff[i] = (addr_s[i] ^ cfg_addr[i]) & cfg_addr_mask[i];
    end

    always_comb begin
        addr_ok = (addr_diff == '0);
        data_ok = !cfg_data_en || (data_s == cfg_data);
        hit     = eval && !rw_s && addr_ok && data_ok;
    end

endmodule

// File: rtl/bwt_hold.sv
`timescale 1ns/1ps
module bwt_hold
    import bwt_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    localparam int WORD_W = ADDR_W + DATA_W,
    localparam int SEL_W  = $clog2(WORD_W / BYTE_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hit,
    input  logic              clr,
    input  logic [ADDR_W-1:0] addr_s,
    input  logic [DATA_W-1:0] data_s,
    input  logic [SEL_W-1:0]  rd_sel,
    output logic [BYTE_W-1:0] rd_byte,
    output logic              trig
);

    logic              trig_q;
    logic [ADDR_W-1:0] cap_addr_q;
    logic [DATA_W-1:0] cap_data_q;
    logic              take;
    logic [WORD_W-1:0] word;
    logic [SEL_W+2:0]  base;

    // a match is taken when idle, or when a clear frees the latch this edge
    assign take = hit && (!trig_q || clr);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            trig_q     <= 1'b0;
            cap_addr_q <= '0;
            cap_data_q <= '0;
        end else if (take) begin
            trig_q     <= 1'b1;
            cap_addr_q <= addr_s;
            cap_data_q <= data_s;
        end else if (clr) begin
            trig_q     <= 1'b0;
            cap_addr_q <= '0;
            cap_data_q <= '0;
        end
    end

    // byte read-out: address bytes low, data bytes high
    always_comb begin
        word    = {cap_data_q, cap_addr_q};
        base    = {rd_sel, 3'b000};
        rd_byte = word[base +: BYTE_W];
    end

    assign trig = trig_q;

    // R7
    trig_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_q && !clr) |=> trig_q);

    // R7
    capture_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_q && !clr) |=> ($stable(cap_addr_q) && $stable(cap_data_q)));

    // R9
    clear_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !hit) |=> (!trig_q && cap_addr_q == '0 && cap_data_q == '0));

    // R10
    match_beats_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && hit) |=> (trig_q && cap_addr_q == $past(addr_s)));

endmodule

// File: rtl/bus_write_trigger.sv
`timescale 1ns/1ps
module bus_write_trigger
    import bwt_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    localparam int SEL_W = $clog2((ADDR_W + DATA_W) / BYTE_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_data,
    input  logic              as_n,
    input  logic              ds_n,
    input  logic              rw,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [ADDR_W-1:0] cfg_addr_mask,
    input  logic              cfg_data_en,
    input  logic [DATA_W-1:0] cfg_data,
    input  logic              clr,
    input  logic [SEL_W-1:0]  rd_sel,
    output logic [BYTE_W-1:0] rd_byte,
    output logic              trig
);

    localparam int PAY_W = ADDR_W + DATA_W + 1;

    logic [1:0]        strb_s;
    logic [PAY_W-1:0]  pay_s;
    logic              as_s;
    logic              ds_s;
    logic              rw_s;
    logic [ADDR_W-1:0] addr_s;
    logic [DATA_W-1:0] data_s;
    logic              eval;
    logic              hit;

    // strobes idle high out of reset
    bwt_sync #(.WIDTH(2), .RST_BIT(1'b1)) u_sync_strb (
        .clk   (clk),
        .rst_n (rst_n),
        .din   ({as_n, ds_n}),
        .dout  (strb_s)
    );

    bwt_sync #(.WIDTH(PAY_W), .RST_BIT(1'b0)) u_sync_pay (
        .clk   (clk),
        .rst_n (rst_n),
        .din   ({rw, bus_data, bus_addr}),
        .dout  (pay_s)
    );

    assign as_s   = strb_s[1];
    assign ds_s   = strb_s[0];
    assign rw_s   = pay_s[PAY_W-1];
    assign data_s = pay_s[ADDR_W +: DATA_W];
    assign addr_s = pay_s[ADDR_W-1:0];

    bwt_cycle_fsm u_fsm (
        .clk   (clk),
        .rst_n (rst_n),
        .as_s  (as_s),
        .ds_s  (ds_s),
        .eval  (eval)
    );

    bwt_match #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_match (
        .eval          (eval),
        .rw_s          (rw_s),
        .addr_s        (addr_s),
        .data_s        (data_s),
        .cfg_addr      (cfg_addr),
        .cfg_addr_mask (cfg_addr_mask),
        .cfg_data_en   (cfg_data_en),
        .cfg_data      (cfg_data),
        .hit           (hit)
    );

    bwt_hold #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_hold (
        .clk     (clk),
        .rst_n   (rst_n),
        .hit     (hit),
        .clr     (clr),
        .addr_s  (addr_s),
        .data_s  (data_s),
        .rd_sel  (rd_sel),
        .rd_byte (rd_byte),
        .trig    (trig)
    );

    // R4
    no_read_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> !rw_s);

    // R3
    hit_on_strobes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> (!as_s && !ds_s));

    // R12
    trig_rise_from_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(trig) |-> $past(hit));

endmodule

// File: tb/bus_write_trigger_tb_top.sv
`timescale 1ns/1ps
module bus_write_trigger_tb_top;

    typedef struct {
        bit          trig;
        logic [31:0] addr;
        logic [31:0] data;
        string       req;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] bus_addr = '0;
    logic [31:0] bus_data = '0;
    logic        as_n = 1'b1;
    logic        ds_n = 1'b1;
    logic        rw = 1'b1;
    logic [31:0] cfg_addr = 32'h9000_1000;
    logic [31:0] cfg_addr_mask = 32'hFFFF_FFFF;
    logic        cfg_data_en = 1'b0;
    logic [31:0] cfg_data = '0;
    logic        clr = 1'b0;
    logic [2:0]  rd_sel = '0;
    logic [7:0]  rd_byte;
    logic        trig;

    int   n_vec = 0;
    int   n_bad = 0;
    bit   done = 1'b0;
    exp_t exp_q[$];

    always #2.5 clk = ~clk;

    bus_write_trigger dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .bus_addr      (bus_addr),
        .bus_data      (bus_data),
        .as_n          (as_n),
        .ds_n          (ds_n),
        .rw            (rw),
        .cfg_addr      (cfg_addr),
        .cfg_addr_mask (cfg_addr_mask),
        .cfg_data_en   (cfg_data_en),
        .cfg_data      (cfg_data),
        .clr           (clr),
        .rd_sel        (rd_sel),
        .rd_byte       (rd_byte),
        .trig          (trig)
    );

    // monitor: pops one expected item, compares flag and all eight bytes
    initial begin
        forever begin
            exp_t        e;
            logic [63:0] w;
            bit          bad;
            wait (exp_q.size() != 0);
            e   = exp_q[0];
            w   = {e.data, e.addr};
            bad = 1'b0;
            n_vec++;
            if (trig !== e.trig) begin
                bad = 1'b1;
                $display("FAIL %s: trig actual %0b expected %0b", e.req, trig, e.trig);
            end
            for (int s = 0; s < 8; s++) begin
                rd_sel = s[2:0];
                #0.2;
                if (rd_byte !== w[s*8 +: 8]) begin
                    bad = 1'b1;
                    $display("FAIL %s: byte %0d actual %02h expected %02h",
                             e.req, s, rd_byte, w[s*8 +: 8]);
                end
            end
            if (bad) n_bad++;
            void'(exp_q.pop_front());
        end
    end

    task automatic expect_state(input bit t, input logic [31:0] a,
                                input logic [31:0] d, input string req);
        exp_t e;
        e.trig = t;
        e.addr = a;
        e.data = d;
        e.req  = req;
        exp_q.push_back(e);
        wait (exp_q.size() == 0);
    endtask

    task automatic bus_cycle(input logic [31:0] a, input logic [31:0] d,
                             input logic r, input int ds_wait, input int hold,
                             input bit drop_ds);
        @(negedge clk);
        bus_addr = a;
        bus_data = d;
        rw       = r;
        as_n     = 1'b0;
        repeat (ds_wait) @(negedge clk);
        ds_n = drop_ds ? 1'b0 : 1'b1;
        repeat (hold) @(negedge clk);
        as_n = 1'b1;
        ds_n = 1'b1;
        rw   = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic pulse_clr();
        @(negedge clk);
        clr = 1'b1;
        @(negedge clk);
        clr = 1'b0;
        @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(5.0 * 20000);
        n_vec++;
        n_bad++;
        $display("FAIL watchdog: run hung, actual running expected finished");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        expect_state(1'b0, 32'h0, 32'h0, "R1 reset");

        // write to another address, then read of the target: no trigger (R4)
        bus_cycle(32'h9000_2000, 32'h1111_2222, 1'b0, 0, 3, 1'b1);
        expect_state(1'b0, 32'h0, 32'h0, "R4 write other addr");
        bus_cycle(32'h9000_1000, 32'h1111_2222, 1'b1, 0, 3, 1'b1);
        expect_state(1'b0, 32'h0, 32'h0, "R4 read target");

        // R3 address strobe only, data strobe never falls
        bus_cycle(32'h9000_1000, 32'h1111_2222, 1'b0, 0, 5, 1'b0);
        expect_state(1'b0, 32'h0, 32'h0, "R3 as only");

        // R2 target-valued glitch entirely between two edges
        @(negedge clk);
        bus_addr = 32'h8000_1000;
        bus_data = 32'h0;
        rw       = 1'b0;
        as_n     = 1'b0;
        ds_n     = 1'b0;
        #0.5 bus_addr = 32'h9000_1000;
        #0.5 bus_addr = 32'hB000_1000;
        repeat (4) @(negedge clk);
        as_n = 1'b1;
        ds_n = 1'b1;
        rw   = 1'b1;
        repeat (4) @(negedge clk);
        expect_state(1'b0, 32'h0, 32'h0, "R2 glitch ignored");

        // R3 late data strobe, R6 data ignored when disabled, R11 byte order
        bus_cycle(32'h9000_1000, 32'hA1B2_C3D4, 1'b0, 3, 3, 1'b1);
        expect_state(1'b1, 32'h9000_1000, 32'hA1B2_C3D4, "R3 R6 R11 target write");

        // R7 later writes, including another target hit, leave it frozen
        bus_cycle(32'h9000_2000, 32'h5555_6666, 1'b0, 0, 3, 1'b1);
        bus_cycle(32'h9000_1000, 32'h7777_8888, 1'b0, 0, 3, 1'b1);
        expect_state(1'b1, 32'h9000_1000, 32'hA1B2_C3D4, "R7 sticky frozen");

        // R9 clear
        pulse_clr();
        expect_state(1'b0, 32'h0, 32'h0, "R9 clear");

        // R5 mask: differing compared bit misses, differing masked bit hits
        cfg_addr      = 32'h0040_1230;
        cfg_addr_mask = 32'hFFFF_FFF0;
        bus_cycle(32'h0041_1230, 32'h0102_0304, 1'b0, 0, 3, 1'b1);
        expect_state(1'b0, 32'h0, 32'h0, "R5 compared bit differs");
        bus_cycle(32'h0040_123C, 32'h0102_0304, 1'b0, 0, 3, 1'b1);
        expect_state(1'b1, 32'h0040_123C, 32'h0102_0304, "R5 masked bit differs");
        pulse_clr();

        // R6 data check enabled
        cfg_addr      = 32'h9000_1000;
        cfg_addr_mask = 32'hFFFF_FFFF;
        cfg_data_en   = 1'b1;
        cfg_data      = 32'hCAFE_F00D;
        bus_cycle(32'h9000_1000, 32'h0000_1234, 1'b0, 0, 3, 1'b1);
        expect_state(1'b0, 32'h0, 32'h0, "R6 wrong data");
        bus_cycle(32'h9000_1000, 32'hCAFE_F00D, 1'b0, 0, 3, 1'b1);
        expect_state(1'b1, 32'h9000_1000, 32'hCAFE_F00D, "R6 right data");
        pulse_clr();
        cfg_data_en = 1'b0;

        // R8 long cycle: clear mid-cycle, no retrigger while strobes held
        @(negedge clk);
        bus_addr = 32'h9000_1000;
        bus_data = 32'h0BAD_BEEF;
        rw       = 1'b0;
        as_n     = 1'b0;
        ds_n     = 1'b0;
        repeat (5) @(negedge clk);
        clr = 1'b1;
        @(negedge clk);
        clr = 1'b0;
        repeat (6) @(negedge clk);
        expect_state(1'b0, 32'h0, 32'h0, "R8 no retrigger in long cycle");
        as_n = 1'b1;
        ds_n = 1'b1;
        rw   = 1'b1;
        repeat (4) @(negedge clk);
        bus_cycle(32'h9000_1000, 32'h0BAD_BEEF, 1'b0, 0, 3, 1'b1);
        expect_state(1'b1, 32'h9000_1000, 32'h0BAD_BEEF, "R8 new cycle matches");
        pulse_clr();

        // R12 latency: flag set after third edge, not earlier
        @(negedge clk);
        bus_addr = 32'h9000_1000;
        bus_data = 32'h2468_ACE0;
        rw       = 1'b0;
        as_n     = 1'b0;
        ds_n     = 1'b0;
        @(negedge clk);
        expect_state(1'b0, 32'h0, 32'h0, "R12 after edge k");
        @(negedge clk);
        expect_state(1'b0, 32'h0, 32'h0, "R12 after edge k+1");
        @(negedge clk);
        expect_state(1'b1, 32'h9000_1000, 32'h2468_ACE0, "R12 after edge k+2");
        as_n = 1'b1;
        ds_n = 1'b1;
        rw   = 1'b1;
        repeat (4) @(negedge clk);
        pulse_clr();

        // R10 clear and new match on the same edge
        cfg_addr_mask = 32'hFFFF_FF00;
        bus_cycle(32'h9000_1011, 32'h1357_9BDF, 1'b0, 0, 3, 1'b1);
        expect_state(1'b1, 32'h9000_1011, 32'h1357_9BDF, "R10 precondition");
        @(negedge clk);
        bus_addr = 32'h9000_1022;
        bus_data = 32'hFEDC_BA98;
        rw       = 1'b0;
        as_n     = 1'b0;
        ds_n     = 1'b0;
        @(negedge clk);
        @(negedge clk);
        clr = 1'b1;
        @(negedge clk);
        clr = 1'b0;
        expect_state(1'b1, 32'h9000_1022, 32'hFEDC_BA98, "R10 match wins");
        as_n = 1'b1;
        ds_n = 1'b1;
        rw   = 1'b1;
        repeat (4) @(negedge clk);

        finish_run();
    end

endmodule